// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. Software programs a command word that holds the frame type, the opcode, the PHY port address and the register or device address. Setting the start bit in that same write launches one frame. The block divides the system clock down to the management clock and shifts the frame out MSB first. On reads it releases the data line, samples the PHY's reply, and then clears the start bit on its own.

Both Clause 22 and Clause 45 frames are supported. For a Clause 45 address frame the 16-bit payload comes from a separate address register. Write frames take their payload from a write-data register. A completed read leaves the received word in a read-data register. A status flag reports a read in which the PHY did not pull the second turnaround bit low. Software polls the start bit before it issues the next command, and it sequences any multi-frame Clause 45 access itself.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register byte offsets are: command 0x00, address 0x04, write data 0x08, read data 0x0C, status 0x10. The address and write-data registers keep bits 15:0 and read them back. The command register keeps these fields and reads them back: register/device address in bits 4:0, port address in bits 9:5, opcode in bits 11:10 and frame-type code in bits 13:12. Bit 14 reads back as the live busy state. After reset every register reads 0.
- R2: A command write with bit 14 set, made while idle, starts a frame. Bit 14 then reads 1 for exactly 128*MDC_HALF system cycles (64 MDC periods) and returns to 0 by itself.
- R3: MDC is low while idle. While a frame runs, MDC rising edges are 2*MDC_HALF system cycles apart.
- R4: Every frame is 64 bits, sent MSB first. The order is 32 ones, then the 2-bit frame-type code as given (0 gives 00 for Clause 45, 1 gives 01 for Clause 22), then the opcode, the 5-bit port address and the 5-bit register/device address.
- R5: An opcode of 00 (Clause 45 address) drives the turnaround as 1 then 0, followed by address register bits 15:0.
- R6: An opcode of 01 (write) drives the turnaround as 1 then 0, followed by write-data register bits 15:0.
- R7: Opcodes with bit 1 set are reads. The output enable is low for frame bits 46 to 63. The 16 bits sampled on the MDC rising edges of bits 48 to 63 land in read-data bits 15:0, MSB first. The read-data register changes only at the end of a read frame.
- R8: Status bit 0 is set when a read samples 1 on the second turnaround bit (frame bit 47). It is cleared when the next command is accepted.
- R9: A command write made while a frame is in progress is ignored. The running frame and the stored command fields stay unchanged.
- R10: While idle the output enable is low and MDIO drives 1. While busy, MDIO changes only on the cycle in which MDC falls.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A command write is taken at the clock edge that follows the strobe, so bit 14 reads 1 from the very next sample. The bench counts the samples taken on falling system-clock edges until the bit drops and expects exactly 128*MDC_HALF. The bench's PHY model records MDIO and its enable on each MDC rising edge. It changes its reply on each MDC falling edge, half an MDC period before the master samples. The read-data and status registers are read only after bit 14 has cleared, because both update on the same edge that ends the frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int FRAME_BITS   = 64;
   localparam int LAST_BIT     = FRAME_BITS - 1;
   localparam int RELEASE_BIT  = 46;
   localparam int TA_CHECK_BIT = 47;
   localparam int DATA_BIT     = 48;
   localparam int IDX_W        = $clog2(FRAME_BITS);

   localparam logic [4:0] OFF_CMD    = 5'h00;
   localparam logic [4:0] OFF_ADDR   = 5'h04;
   localparam logic [4:0] OFF_WDATA  = 5'h08;
   localparam logic [4:0] OFF_RDATA  = 5'h0C;
   localparam logic [4:0] OFF_STATUS = 5'h10;

   localparam int GO_BIT = 14;

   typedef struct packed {
      logic [1:0] kind;
      logic [1:0] op;
      logic [4:0] port;
      logic [4:0] reg_dev;
   } mgmt_cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int HALF = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic          term;

   assign term      = run && (cnt == CW'(HALF - 1));
   assign rise_tick = term && !mdc;
   assign fall_tick = term && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (term) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
   import mdio_mgmt_pkg::*;
(
   input  mgmt_cmd_t                cmd,
   input  logic [15:0]              addr_word,
   input  logic [15:0]              wdata_word,
   output logic [FRAME_BITS-1:0]    frame,
   output logic                     is_read
);
   logic [15:0] payload;

   always_comb begin
      is_read = cmd.op[1];
      payload = (cmd.op == 2'b00) ? addr_word : wdata_word;
      frame   = {32'hFFFF_FFFF, cmd.kind, cmd.op, cmd.port, cmd.reg_dev, 2'b10, payload};
   end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_mgmt_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  launch,
   input  logic [FRAME_BITS-1:0] frame,
   input  logic                  is_read,
   input  logic                  rise_tick,
   input  logic                  fall_tick,
   input  logic                  mdio_i,
   output logic                  busy,
   output logic                  mdio_o,
   output logic                  mdio_oe,
   output logic                  done,
   output logic                  rd_active,
   output logic [15:0]           rx_word,
   output logic                  ta_fail
);
   logic [FRAME_BITS-1:0] shreg;
   logic [IDX_W-1:0]      idx;
   logic                  last;

   assign last = (idx == IDX_W'(LAST_BIT));
   assign done = busy && fall_tick && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         shreg     <= '0;
         idx       <= '0;
         rd_active <= 1'b0;
         rx_word   <= '0;
         ta_fail   <= 1'b0;
         mdio_o    <= 1'b1;
         mdio_oe   <= 1'b0;
      end else if (!busy) begin
         if (launch) begin
            busy      <= 1'b1;
            shreg     <= frame;
            idx       <= '0;
            rd_active <= is_read;
            rx_word   <= '0;
            ta_fail   <= 1'b0;
            mdio_o    <= frame[FRAME_BITS-1];
            mdio_oe   <= 1'b1;
         end
      end else begin
         if (rise_tick && rd_active) begin
            if (idx == IDX_W'(TA_CHECK_BIT))
               ta_fail <= mdio_i;
            if (idx >= IDX_W'(DATA_BIT))
               rx_word <= {rx_word[14:0], mdio_i};
         end
         if (fall_tick) begin
            if (last) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
               mdio_o  <= 1'b1;
            end else begin
               idx     <= idx + 1'b1;
               shreg   <= shreg << 1;
               mdio_o  <= shreg[FRAME_BITS-2];
               mdio_oe <= !(rd_active && (idx >= IDX_W'(RELEASE_BIT - 1)));
            end
         end
      end
   end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int MDC_HALF = 40,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   localparam int CMD_W = $bits(mgmt_cmd_t);

   generate
      if (MDC_HALF < 2) begin : g_bad_half
         $error("MDC_HALF must be at least 2");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must be at least 16");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must be at least 5");
      end
   endgenerate

   mgmt_cmd_t             cmd_q;
   logic [15:0]           addr_q;
   logic [15:0]           wdata_q;
   logic [15:0]           rdata_q;
   logic                  fail_q;
   logic                  busy;
   logic                  launch;
   logic                  cmd_sel;
   logic                  rise_tick;
   logic                  fall_tick;
   logic                  done;
   logic                  rd_active;
   logic                  ta_fail;
   logic                  is_read;
   logic [15:0]           rx_word;
   logic [FRAME_BITS-1:0] frame;
   mgmt_cmd_t             new_cmd;
   logic                  unused_wbits;

   assign unused_wbits = ^reg_wdata;
   assign new_cmd = mgmt_cmd_t'(reg_wdata[CMD_W-1:0]);
   assign cmd_sel = reg_we && (reg_addr == ADDR_W'(OFF_CMD)) && !busy;
   assign launch  = cmd_sel && reg_wdata[GO_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         fail_q  <= 1'b0;
      end else begin
         if (cmd_sel)
            cmd_q <= new_cmd;
         if (reg_we && reg_addr == ADDR_W'(OFF_ADDR))
            addr_q <= reg_wdata[15:0];
         if (reg_we && reg_addr == ADDR_W'(OFF_WDATA))
            wdata_q <= reg_wdata[15:0];
         if (launch)
            fail_q <= 1'b0;
         else if (done)
            fail_q <= ta_fail;
         if (done && rd_active)
            rdata_q <= rx_word;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFF_CMD):    reg_rdata = DATA_W'({busy, cmd_q});
         ADDR_W'(OFF_ADDR):   reg_rdata = DATA_W'(addr_q);
         ADDR_W'(OFF_WDATA):  reg_rdata = DATA_W'(wdata_q);
         ADDR_W'(OFF_RDATA):  reg_rdata = DATA_W'(rdata_q);
         ADDR_W'(OFF_STATUS): reg_rdata = DATA_W'(fail_q);
         default:             reg_rdata = '0;
      endcase
   end

   mdio_frame_build u_build (
      .cmd        (new_cmd),
      .addr_word  (addr_q),
      .wdata_word (wdata_q),
      .frame      (frame),
      .is_read    (is_read)
   );

   mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .frame     (frame),
      .is_read   (is_read),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_i    (mdio_i),
      .busy      (busy),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .done      (done),
      .rd_active (rd_active),
      .rx_word   (rx_word),
      .ta_fail   (ta_fail)
   );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic [15:0] rdata_q,
   input logic        fail_q
);
   // R3
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   // R10
   oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && mdio_o));

   // R10
   mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

   // R7
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(rdata_q));

   // R8
   fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !fail_q);
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .rdata_q (rdata_q),
   .fail_q  (fail_q)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
   localparam int HALF = 4;
   localparam real TCLK = 5.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [63:0] resp;
   logic [63:0] cap_o, cap_oe;
   int          ridx;
   realtime     last_rise;
   int          per_bad = 0;

   always #(TCLK/2) clk = ~clk;

   mdio_mgmt_master #(.MDC_HALF(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model: capture on MDC rise, update reply on MDC fall
   always @(posedge mdc) begin
      if (ridx < 64) begin
         cap_o[63-ridx]  = mdio_o;
         cap_oe[63-ridx] = mdio_oe;
      end
      ridx = ridx + 1;
      if (last_rise > 0.0) begin
         if ($realtime - last_rise > 2*HALF*TCLK + 0.1 ||
             $realtime - last_rise < 2*HALF*TCLK - 0.1)
            per_bad = per_bad + 1;
      end
      last_rise = $realtime;
   end

   always @(negedge mdc) begin
      if (ridx < 64) mdio_i = resp[63-ridx];
      else           mdio_i = 1'b1;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [63:0] exp_frame(input logic [1:0] k, input logic [1:0] op,
         input logic [4:0] p, input logic [4:0] r, input logic [15:0] a, input logic [15:0] w);
      return {32'hFFFF_FFFF, k, op, p, r, 2'b10, (op == 2'b00) ? a : w};
   endfunction

   function automatic logic [63:0] exp_oe(input logic [1:0] op);
      return op[1] ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
   endfunction

   function automatic logic [31:0] cmd_word(input logic go, input logic [1:0] k, input logic [1:0] op,
         input logic [4:0] p, input logic [4:0] r);
      return {17'b0, go, k, op, p, r};
   endfunction

   task automatic wait_idle(output int cnt);
      logic [31:0] d;
      cnt = 0;
      reg_read(5'h00, d);
      while (d[14] && cnt < 100000) begin
         cnt++;
         @(negedge clk);
         reg_read(5'h00, d);
      end
   endtask

   task automatic run_frame(input logic [1:0] k, input logic [1:0] op, input logic [4:0] p,
         input logic [4:0] r, input logic [15:0] a, input logic [15:0] w,
         input logic [15:0] rdat, input bit ta_bad);
      int cnt;
      logic [31:0] d;
      logic [63:0] ef, eo;
      resp = {{46{1'b1}}, 1'b1, ta_bad, rdat};
      reg_write(5'h04, {16'hDEAD, a});
      reg_write(5'h08, {16'hBEEF, w});
      ridx = 0; last_rise = 0.0; cap_o = '0; cap_oe = '0;
      mdio_i = resp[63];
      reg_write(5'h00, cmd_word(1'b1, k, op, p, r));
      wait_idle(cnt);
      chk(cnt == 128*HALF, "R2 busy length", 64'(cnt), 64'(128*HALF));
      ef = exp_frame(k, op, p, r, a, w);
      eo = exp_oe(op);
      chk(cap_o[63:18] == ef[63:18], "R4 preamble and header", cap_o, ef);
      chk(cap_oe == eo, op[1] ? "R7 output enable release" : "R6 output enable", cap_oe, eo);
      if (!op[1])
         chk(cap_o[17:0] == ef[17:0], (op == 2'b00) ? "R5 address payload" : "R6 write payload",
             64'(cap_o[17:0]), 64'(ef[17:0]));
      reg_read(5'h0C, d);
      if (op[1]) chk(d == {16'b0, rdat}, "R7 read data", 64'(d), 64'(rdat));
      reg_read(5'h10, d);
      chk(d == 32'(op[1] & ta_bad), "R8 status", 64'(d), 64'(op[1] & ta_bad));
      reg_read(5'h00, d);
      chk(d == cmd_word(1'b0, k, op, p, r), "R1 command readback", 64'(d),
          64'(cmd_word(1'b0, k, op, p, r)));
   endtask

   initial begin
      logic [31:0] d;
      int cnt;
      logic [63:0] ef;
      void'($urandom(32'd1234));
      ridx = 64; resp = '1; last_rise = 0.0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R3 / R10: reset state
      reg_read(5'h00, d); chk(d == 0, "R1 reset command", 64'(d), 0);
      reg_read(5'h0C, d); chk(d == 0, "R1 reset read data", 64'(d), 0);
      reg_read(5'h10, d); chk(d == 0, "R1 reset status", 64'(d), 0);
      chk(!mdc, "R3 idle mdc", 64'(mdc), 0);
      chk(!mdio_oe, "R10 idle oe", 64'(mdio_oe), 0);
      // R1: register readback, no launch without bit 14
      reg_write(5'h04, 32'hFFFF_1234);
      reg_read(5'h04, d); chk(d == 32'h1234, "R1 address readback", 64'(d), 64'h1234);
      reg_write(5'h00, cmd_word(1'b0, 2'd1, 2'd2, 5'd3, 5'd4));
      repeat (3) @(negedge clk);
      reg_read(5'h00, d); chk(d == cmd_word(1'b0, 2'd1, 2'd2, 5'd3, 5'd4), "R1 no launch", 64'(d),
          64'(cmd_word(1'b0, 2'd1, 2'd2, 5'd3, 5'd4)));
      chk(!mdc && !mdio_oe, "R2 no frame without go bit", 64'({mdc, mdio_oe}), 0);
      // directed frames
      run_frame(2'd1, 2'b01, 5'd1, 5'd0, 16'h0000, 16'hA5C3, 16'h0, 1'b0);
      run_frame(2'd1, 2'b10, 5'd31, 5'd31, 16'h0, 16'h0, 16'h8001, 1'b0);
      run_frame(2'd0, 2'b00, 5'd7, 5'd3, 16'hFFFF, 16'h0, 16'h0, 1'b0);
      run_frame(2'd0, 2'b01, 5'd0, 5'd1, 16'h1111, 16'h0000, 16'h0, 1'b0);
      run_frame(2'd0, 2'b11, 5'd9, 5'd5, 16'h0, 16'h0, 16'h7FFE, 1'b0);
      run_frame(2'd0, 2'b10, 5'd2, 5'd30, 16'h0, 16'h0, 16'h0000, 1'b0);
      // R8: failed read then cleared by next command
      run_frame(2'd1, 2'b10, 5'd4, 5'd2, 16'h0, 16'h0, 16'h1234, 1'b1);
      run_frame(2'd1, 2'b01, 5'd4, 5'd2, 16'h0, 16'h5555, 16'h0, 1'b0);
      // R9: command written while busy is ignored
      resp = '1; ridx = 0; last_rise = 0.0; mdio_i = 1'b1;
      reg_write(5'h08, 32'h0000_C0DE);
      reg_write(5'h00, cmd_word(1'b1, 2'd1, 2'b01, 5'd5, 5'd6));
      repeat (40) @(negedge clk);
      reg_write(5'h00, cmd_word(1'b1, 2'd0, 2'b11, 5'd20, 5'd21));
      wait_idle(cnt);
      ef = exp_frame(2'd1, 2'b01, 5'd5, 5'd6, 16'h0, 16'hC0DE);
      chk(cap_o == ef, "R9 running frame kept", cap_o, ef);
      reg_read(5'h00, d);
      chk(d == cmd_word(1'b0, 2'd1, 2'b01, 5'd5, 5'd6), "R9 fields kept", 64'(d),
          64'(cmd_word(1'b0, 2'd1, 2'b01, 5'd5, 5'd6)));
      repeat (3) @(negedge clk);
      chk(!mdc && !mdio_oe, "R9 no second frame", 64'({mdc, mdio_oe}), 0);
      // constrained random frames
      for (int i = 0; i < 10; i++) begin
         run_frame(2'($urandom % 2), 2'($urandom), 5'($urandom), 5'($urandom),
                   16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom % 4 == 0));
      end
      chk(per_bad == 0, "R3 mdc period", 64'(per_bad), 0);
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule